// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the 8-bit datapath of an accumulator-style microcontroller core. On each clock edge it takes the accumulator byte, a second operand byte, the current carry, auxiliary-carry and overflow flags, and a 4-bit operation code. One cycle later it presents a primary result byte, a secondary result byte and the four status flags: carry, auxiliary carry, overflow and parity.

The operations are binary add with and without carry, subtract with borrow, decimal correction after a packed-BCD addition, the bitwise operations, clear and complement, four rotate forms, nibble exchange, and a single-step unsigned multiply and divide. The secondary byte holds the high product byte or the remainder, and otherwise returns the second operand unchanged, so the surrounding core can write it back as the B register. Any flag that an operation does not define is passed through from its input, so the core can write all four flags back after every operation. Operand fetch, addressing and instruction decode live outside the block.

Top module: `acc_alu_core`

## Requirements
- R1: All outputs are registered, and each output reflects the inputs present at the previous rising clock edge. While `rst_n` is low, every output reads 0.
- R2: Code 0 adds the accumulator and the operand. Code 1 also adds the carry input. CY is the carry out of bit 7 and AC is the carry out of bit 3. OV is set when both operands have the same sign and the sum's sign differs from it.
- R3: Code 2 computes accumulator minus operand minus the carry input, modulo 256. CY is set when the true difference is negative, and AC is set when the low nibble borrows. OV is set when the operand signs differ and the result's sign differs from the accumulator's sign.
- R4: Code 3 applies the decimal correction. It adds 06h when the low nibble exceeds 9 or AC is 1. It then adds 60h when the high nibble exceeds 9 or CY is 1, or when the first step carried out. A carry out of either step sets CY. CY is never cleared by this operation.
- R5: Codes 4, 5 and 6 give the AND, OR and XOR of the accumulator and the operand. Code 7 gives 00h and code 8 gives the bitwise inverse of the accumulator. For these codes CY, AC and OV keep their input values.
- R6: Code 9 rotates the accumulator left and code 10 rotates it right, in both cases over its 8 bits. Code 11 rotates left through carry, so bit 7 goes to CY and the old CY goes to bit 0. Code 12 rotates right through carry, so bit 0 goes to CY and the old CY goes to bit 7. Code 13 exchanges bits 7..4 with bits 3..0.
- R7: Code 14 multiplies the accumulator by the operand. The low product byte goes to the result and the high byte to the secondary output. CY is cleared, and OV is set exactly when the product exceeds 255.
- R8: Code 15 divides the accumulator by the operand. The quotient goes to the result and the remainder to the secondary output, and CY is cleared. A zero divisor sets OV, and its result and remainder are unspecified. Any other divisor clears OV.
- R9: The parity output is 1 exactly when the result byte has an odd number of ones.
- R10: For every code other than 14 and 15, the secondary output equals the operand. Codes 3 through 15 leave AC at its input value. Codes 3 through 13 leave OV at its input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand (B register for multiply/divide) |
| cy_i | input | 1 | Carry flag in |
| ac_i | input | 1 | Auxiliary carry flag in |
| ov_i | input | 1 | Overflow flag in |
| res_o | output | 8 | Primary result byte |
| res_hi_o | output | 8 | Secondary result byte |
| cy_o | output | 1 | Carry flag out |
| ac_o | output | 1 | Auxiliary carry flag out |
| ov_o | output | 1 | Overflow flag out |
| par_o | output | 1 | Parity of the result byte |

## Verification
On every cycle the assertions check the properties that hold no matter what the operand values are. Multiply and divide clear the carry. The multiply overflow tracks a nonzero high byte. A zero divisor raises the overflow, and a nonzero divisor leaves a remainder below the divisor. Decimal correction never drops an incoming carry. Parity agrees with the result, and the secondary output echoes the operand wherever it should. The actual result values of add, subtract, decimal correction, the rotates and the quotient are shown only by the bench's sweep, which runs every accumulator value against a spread of operand and flag values and compares each output with arithmetic computed independently.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    parameter int DATA_W = 8;
    parameter int NIB_W  = DATA_W / 2;
    parameter int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_DA   = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CLR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_RL   = 4'd9,
        OP_RR   = 4'd10,
        OP_RLC  = 4'd11,
        OP_RRC  = 4'd12,
        OP_SWAP = 4'd13,
        OP_MUL  = 4'd14,
        OP_DIV  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] hi;
        logic              cy;
        logic              ac;
        logic              ov;
        logic              p;
    } alu_out_t;

endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
module acc_alu_addsub #(
    parameter int W = acc_alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         ac,
    output logic         ov
);
    localparam int H = W / 2;

    logic [W-1:0]   bx;
    logic           ci;
    logic [H:0]     lo_s;
    logic [W-H:0]   hi_s;

    always_comb begin
        // subtract as a + ~b + ~borrow; carries then mean "no borrow"
        bx   = sub ? ~b : b;
        ci   = sub ? ~cin : cin;
        lo_s = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, ci};
        hi_s = {1'b0, a[W-1:H]} + {1'b0, bx[W-1:H]} + {{(W-H){1'b0}}, lo_s[H]};
        res  = {hi_s[W-H-1:0], lo_s[H-1:0]};
        cy   = hi_s[W-H] ^ sub;
        ac   = lo_s[H] ^ sub;
        ov   = (a[W-1] == bx[W-1]) && (res[W-1] != a[W-1]);
    end

endmodule

// File: rtl/acc_alu_decadj.sv
`timescale 1ns/1ps
module acc_alu_decadj #(
    parameter int W = acc_alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         ac,
    input  logic         cy,
    output logic [W-1:0] res,
    output logic         cy_o
);
    localparam int H = W / 2;
    localparam logic [W:0]   LO_FIX = (W+1)'(6);
    localparam logic [W:0]   HI_FIX = (W+1)'(6) << H;
    localparam logic [H-1:0] DIG_MAX = H'(9);

    logic [W:0] t1;
    logic [W:0] t2;
    logic       c1;
    logic       fix_lo;
    logic       fix_hi;

    always_comb begin
        fix_lo = (a[H-1:0] > DIG_MAX) || ac;
        t1     = fix_lo ? ({1'b0, a} + LO_FIX) : {1'b0, a};
        c1     = cy | t1[W];
        fix_hi = (t1[W-1:H] > DIG_MAX) || c1;
        t2     = fix_hi ? ({1'b0, t1[W-1:0]} + HI_FIX) : {1'b0, t1[W-1:0]};
        res    = t2[W-1:0];
        cy_o   = c1 | t2[W];
    end

endmodule

// File: rtl/acc_alu_bitops.sv
`timescale 1ns/1ps
module acc_alu_bitops #(
    parameter int W = acc_alu_pkg::DATA_W
) (
    input  acc_alu_pkg::alu_op_e op,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  logic                 cy,
    output logic [W-1:0]         res,
    output logic                 cy_o
);
    import acc_alu_pkg::*;
    localparam int H = W / 2;

    always_comb begin
        res  = a;
        cy_o = cy;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CLR:  res = '0;
            OP_CPL:  res = ~a;
            OP_RL:   res = {a[W-2:0], a[W-1]};
            OP_RR:   res = {a[0], a[W-1:1]};
            OP_RLC:  begin res = {a[W-2:0], cy}; cy_o = a[W-1]; end
            OP_RRC:  begin res = {cy, a[W-1:1]}; cy_o = a[0];   end
            OP_SWAP: res = {a[H-1:0], a[W-1:H]};
            default: res = a;
        endcase
    end

endmodule

// File: rtl/acc_alu_muldiv.sv
`timescale 1ns/1ps
module acc_alu_muldiv #(
    parameter int W = acc_alu_pkg::DATA_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod,
    output logic [W-1:0]   quo,
    output logic [W-1:0]   rem,
    output logic           dz
);
    localparam int PW = 2 * W;

    logic [W-1:0][PW-1:0] pp;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_pp
            assign pp[gi] = b[gi] ? ({{W{1'b0}}, a} << gi) : '0;
        end
    endgenerate

    always_comb begin
        prod = '0;
        for (int i = 0; i < W; i++) begin
            prod = prod + pp[i];
        end
    end

    // restoring division, one quotient bit per step, MSB first
    always_comb begin
        logic [W-1:0] r_v;
        logic [W:0]   part;
        r_v  = '0;
        part = '0;
        quo  = '0;
        for (int i = W - 1; i >= 0; i--) begin
            part = {r_v, a[i]};
            if (part >= {1'b0, b}) begin
                quo[i] = 1'b1;
                part   = part - {1'b0, b};
            end
            r_v = part[W-1:0];
        end
        rem = r_v;
        dz  = (b == '0);
    end

endmodule

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
module acc_alu_core (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] op_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic       cy_i,
    input  logic       ac_i,
    input  logic       ov_i,
    output logic [7:0] res_o,
    output logic [7:0] res_hi_o,
    output logic       cy_o,
    output logic       ac_o,
    output logic       ov_o,
    output logic       par_o
);
    import acc_alu_pkg::*;
    localparam int W = DATA_W;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic [W-1:0]   as_res;
    logic           as_cy, as_ac, as_ov;
    logic [W-1:0]   da_res;
    logic           da_cy;
    logic [W-1:0]   bo_res;
    logic           bo_cy;
    logic [2*W-1:0] md_prod;
    logic [W-1:0]   md_quo, md_rem;
    logic           md_dz;

    acc_alu_addsub #(.W(W)) u_addsub (
        .a   (acc_i),
        .b   (opnd_i),
        .cin (op != OP_ADD && cy_i),
        .sub (op == OP_SUBB),
        .res (as_res),
        .cy  (as_cy),
        .ac  (as_ac),
        .ov  (as_ov)
    );

    acc_alu_decadj #(.W(W)) u_decadj (
        .a    (acc_i),
        .ac   (ac_i),
        .cy   (cy_i),
        .res  (da_res),
        .cy_o (da_cy)
    );

    acc_alu_bitops #(.W(W)) u_bitops (
        .op   (op),
        .a    (acc_i),
        .b    (opnd_i),
        .cy   (cy_i),
        .res  (bo_res),
        .cy_o (bo_cy)
    );

    acc_alu_muldiv #(.W(W)) u_muldiv (
        .a    (acc_i),
        .b    (opnd_i),
        .prod (md_prod),
        .quo  (md_quo),
        .rem  (md_rem),
        .dz   (md_dz)
    );

    alu_out_t   out_d, out_q;
    alu_op_e    op_d, op_q;
    logic [W-1:0] opnd_d, opnd_q;
    logic       cyin_d, cyin_q;

    always_comb begin
        out_d     = '0;
        out_d.res = acc_i;
        out_d.hi  = opnd_i;
        out_d.cy  = cy_i;
        out_d.ac  = ac_i;
        out_d.ov  = ov_i;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                out_d.res = as_res;
                out_d.cy  = as_cy;
                out_d.ac  = as_ac;
                out_d.ov  = as_ov;
            end
            OP_DA: begin
                out_d.res = da_res;
                out_d.cy  = da_cy;
            end
            OP_MUL: begin
                out_d.res = md_prod[W-1:0];
                out_d.hi  = md_prod[2*W-1:W];
                out_d.cy  = 1'b0;
                out_d.ov  = |md_prod[2*W-1:W];
            end
            OP_DIV: begin
                out_d.res = md_quo;
                out_d.hi  = md_rem;
                out_d.cy  = 1'b0;
                out_d.ov  = md_dz;
            end
            default: begin
                out_d.res = bo_res;
                out_d.cy  = bo_cy;
            end
        endcase
        out_d.p = ^out_d.res;
        op_d    = op;
        opnd_d  = opnd_i;
        cyin_d  = cy_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            op_q   <= OP_ADD;
            opnd_q <= '0;
            cyin_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            op_q   <= op_d;
            opnd_q <= opnd_d;
            cyin_q <= cyin_d;
        end
    end

    assign res_o    = out_q.res;
    assign res_hi_o = out_q.hi;
    assign cy_o     = out_q.cy;
    assign ac_o     = out_q.ac;
    assign ov_o     = out_q.ov;
    assign par_o    = out_q.p;

    AST_MUL_CY_CLR: assert property (@(posedge clk) disable iff (!rst_n) (op_q == OP_MUL) |-> !cy_o); // R7
    AST_MUL_OV: assert property (@(posedge clk) disable iff (!rst_n) (op_q == OP_MUL) |-> (ov_o == (res_hi_o != 8'h00))); // R7
    AST_DIV_CY_CLR: assert property (@(posedge clk) disable iff (!rst_n) (op_q == OP_DIV) |-> !cy_o); // R8
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (op_q == OP_DIV) |-> (ov_o == (opnd_q == 8'h00))); // R8
    AST_DIV_REM: assert property (@(posedge clk) disable iff (!rst_n) (op_q == OP_DIV && opnd_q != 8'h00) |-> (res_hi_o < opnd_q)); // R8
    AST_DA_CY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (op_q == OP_DA && cyin_q) |-> cy_o); // R4
    AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n) par_o == ($countones(res_o) % 2 == 1)); // R9
    AST_HI_PASS: assert property (@(posedge clk) disable iff (!rst_n) (op_q != OP_MUL && op_q != OP_DIV) |-> (res_hi_o == opnd_q)); // R10

endmodule

// File: tb/tb_acc_alu_core.sv
`timescale 1ns/1ps
module tb_acc_alu_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0, opnd_i = '0;
    logic       cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
    logic [7:0] res_o, res_hi_o;
    logic       cy_o, ac_o, ov_o, par_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    acc_alu_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i), .res_o(res_o), .res_hi_o(res_hi_o),
        .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (op=%0d a=%0h b=%0h cy=%0b ac=%0b)",
                     tag, what, act, exp, op_i, acc_i, opnd_i, cy_i, ac_i);
        end
    endtask

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // drive at a falling edge, registered result checked at the next falling edge
    task automatic run_vec(input int o, input int a, input int b, input int c, input int h, input int v);
        int er, eh, ec, ea, ev, s, s2, cin, t;
        bit skip;
        string tag;
        op_i = o[3:0]; acc_i = a[7:0]; opnd_i = b[7:0];
        cy_i = c[0]; ac_i = h[0]; ov_i = v[0];
        @(negedge clk);
        er = a; eh = b; ec = c; ea = h; ev = v; skip = 1'b0; tag = "R5";
        case (o)
            0, 1: begin
                tag = "R2";
                cin = (o == 1) ? c : 0;
                s = a + b + cin;
                er = s & 255; ec = int'(s > 255);
                ea = int'(((a & 15) + (b & 15) + cin) > 15);
                s2 = sgn(a) + sgn(b) + cin;
                ev = int'(s2 > 127 || s2 < -128);
            end
            2: begin
                tag = "R3";
                s = a - b - c;
                er = s & 255; ec = int'(s < 0);
                ea = int'(((a & 15) - (b & 15) - c) < 0);
                s2 = sgn(a) - sgn(b) - c;
                ev = int'(s2 > 127 || s2 < -128);
            end
            3: begin
                tag = "R4";
                t = a;
                if ((t & 15) > 9 || h == 1) begin t = t + 6; if (t > 255) ec = 1; t = t & 255; end
                if ((t >> 4) > 9 || ec == 1) begin t = t + 96; if (t > 255) ec = 1; t = t & 255; end
                er = t;
            end
            4: er = a & b;
            5: er = a | b;
            6: er = a ^ b;
            7: er = 0;
            8: er = (~a) & 255;
            9:  begin tag = "R6"; er = ((a << 1) | (a >> 7)) & 255; end
            10: begin tag = "R6"; er = ((a >> 1) | (a << 7)) & 255; end
            11: begin tag = "R6"; er = ((a << 1) | c) & 255; ec = a >> 7; end
            12: begin tag = "R6"; er = (a >> 1) | (c << 7); ec = a & 1; end
            13: begin tag = "R6"; er = ((a << 4) | (a >> 4)) & 255; end
            14: begin
                tag = "R7";
                s = a * b;
                er = s & 255; eh = s >> 8; ec = 0; ev = int'(s > 255);
            end
            default: begin
                tag = "R8";
                ec = 0;
                if (b == 0) begin ev = 1; skip = 1'b1; end
                else begin er = a / b; eh = a % b; ev = 0; end
            end
        endcase
        if (!skip) begin
            chk(tag, "result", int'(res_o), er);
            chk((o < 14) ? "R10" : tag, "second byte", int'(res_hi_o), eh);
            chk("R9", "parity", int'(par_o), $countones(er) % 2);
        end else begin
            chk("R9", "parity", int'(par_o), $countones(res_o) % 2);
        end
        chk(tag, "carry", int'(cy_o), ec);
        chk((o < 3) ? tag : "R10", "aux carry", int'(ac_o), ea);
        chk((o < 3 || o > 13) ? tag : "R10", "overflow", int'(ov_o), ev);
    endtask

    initial begin : wd
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset holds every output at zero even with live inputs
        op_i = 4'd14; acc_i = 8'hFF; opnd_i = 8'hFF; cy_i = 1'b1; ac_i = 1'b1; ov_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "reset result", int'(res_o), 0);
        chk("R1", "reset second byte", int'(res_hi_o), 0);
        chk("R1", "reset flags", int'({cy_o, ac_o, ov_o, par_o}), 0);
        rst_n = 1'b1;

        // R1 latency plus the worked examples
        run_vec(0, 'hF5, 'h0B, 0, 0, 0);   // R2: 00h, CY=1 AC=1 P=0
        chk("R1", "one-cycle result", int'(res_o), 0);
        run_vec(1, 'h63, 'h23, 0, 0, 0);   // R2: 86h, OV=1 P=1
        run_vec(14, 'h25, 'h65, 1, 0, 0);  // R7: 0E99h
        run_vec(15, 95, 10, 1, 0, 0);      // R8: 9 rem 5
        run_vec(15, 'h40, 0, 1, 0, 0);     // R8: divide by zero
        run_vec(3, 'h99, 'h00, 1, 0, 0);   // R4: incoming carry kept
        run_vec(3, 'h9A, 'h00, 0, 0, 0);   // R4: both nibble fixes, carry out
        run_vec(2, 'h4C, 'h6E, 0, 0, 0);   // R3: negative difference

        // sweep: every opcode, every accumulator value, 16 operand values
        for (int o = 0; o < 16; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 16; k++) begin
                    run_vec(o, a, k * 17, (a ^ k) & 1, ((a >> 1) ^ k) & 1, (k >> 1) & 1);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule